// File: doc/BRIEF.md
# Scatter-Gather Element Fetch Sequencer

This block pulls one scatter-gather element out of host memory and into a small local buffer. A start pulse comes with a 32-bit pointer to the next element. The sequencer then latches the pointer and copies it into the host address register. It programs the 24-bit host byte count one byte at a time and writes the control word that starts a host-to-local DMA with the FIFO cleared. It waits until the element has arrived, then loads the bus-side transfer counter from the programmed host count and moves the pointer on by one element.

The host side has two streams, both valid/ready. The block raises a read request carrying the address and the length. It holds that request, with address and length unchanged, until the host accepts it. Element bytes then come back on a byte stream. A byte is taken only in a cycle where both valid and ready are high. The host may hold valid low for any number of cycles. Ready is high only while the transfer is active and bytes are still owed. The element is read as little-endian: a 32-bit buffer address first, then a 32-bit byte count.

Top module: `sg_fetch_seq`

## Requirements
- R1: After reset, busy, done, rd_req_valid and hdata_ready are 0, and ctrl_word, stcnt and sg_ptr are 0.
- R2: The host count is written through cnt_wr_en/cnt_wr_sel/cnt_wr_byte in three consecutive cycles with sel 0, then 1, then 2. The bytes are the element size's bytes 0, 1 and 2, which with the default 8-byte element gives 0x08, 0x00, 0x00.
- R3: The read request carries rd_req_addr equal to the start pointer and rd_req_len equal to the element size.
- R4: ctrl_word is 0x0D while the read request is pending: host DMA enable 0x08, host-to-local direction 0x04 and FIFO reset 0x01. It is 0x0C while bytes are being received, and 0x00 once done is raised.
- R5: desc_addr is bytes 0..3 of the element and desc_count is bytes 4..7, each little-endian, so byte 0 is the least significant.
- R6: When done is high, stcnt equals the programmed host count, which is the element size.
- R7: done is high for exactly one cycle per fetch. At that cycle sg_ptr equals the start pointer plus the element size.
- R8: A start pulse while busy is ignored. The running fetch finishes with its original pointer.
- R9: An unaccepted read request keeps rd_req_valid high with a stable address. A byte is consumed only when hdata_valid and hdata_ready are both high. Neither rd_req_valid nor hdata_ready is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| next_ptr | input | 32 | Host address of the element to fetch |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| sg_ptr | output | 32 | Pointer advanced past the fetched element |
| ctrl_word | output | 8 | DMA control word |
| cnt_wr_en | output | 1 | Host count byte write strobe |
| cnt_wr_sel | output | 2 | Host count byte index |
| cnt_wr_byte | output | 8 | Host count byte value |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read request host address |
| rd_req_len | output | 24 | Read request byte length |
| hdata_valid | input | 1 | Host byte valid |
| hdata_ready | output | 1 | Block can take a host byte |
| hdata | input | 8 | Host byte |
| desc_addr | output | 32 | Element buffer address, little-endian |
| desc_count | output | 32 | Element byte count, little-endian |
| stcnt | output | 24 | Bus-side transfer counter |

## Verification
The hardest case to reach is a start pulse that lands while the DMA is partway through a transfer the host keeps stalling. The stall has to last long enough that the wrong pointer would still change the request address or the element bytes. The bench holds back valid at random on the byte stream and delays request acceptance. While the fetch is busy it injects a start with a different pointer, then checks the finished element against the original pointer's memory contents. A directed case with no stalls at all checks back-to-back byte acceptance.

// File: rtl/sg_fetch_pkg.sv
package sg_fetch_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LDPTR, ST_CNT0, ST_CNT1, ST_CNT2,
    ST_GO, ST_XFER, ST_MIRROR, ST_DONE
  } fetch_state_t;

  localparam logic [7:0] CTRL_HOST_EN  = 8'h08;
  localparam logic [7:0] CTRL_TO_LOCAL = 8'h04;
  localparam logic [7:0] CTRL_FLUSH    = 8'h01;
endpackage

// File: rtl/sg_cnt_regs.sv
module sg_cnt_regs #(
  parameter int ADDR_W    = 32,
  parameter int CNT_BYTES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   addr_ld,
  input  logic [ADDR_W-1:0]      addr_in,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [7:0]             wr_byte,
  output logic [ADDR_W-1:0]      haddr,
  output logic [8*CNT_BYTES-1:0] hcnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) haddr <= '0;
    else if (addr_ld) haddr <= addr_in;
  end

  for (genvar g = 0; g < CNT_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) hcnt[8*g +: 8] <= '0;
      else if (wr_en && wr_sel == 2'(g)) hcnt[8*g +: 8] <= wr_byte;
    end
  end
endmodule

// File: rtl/sg_host_dma.sv
module sg_host_dma #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 24,
  parameter int BUF_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_on,
  input  logic                   xfer_on,
  input  logic [ADDR_W-1:0]      haddr,
  input  logic [CNT_W-1:0]       hcnt,
  output logic                   rd_req_valid,
  input  logic                   rd_req_ready,
  output logic [ADDR_W-1:0]      rd_req_addr,
  output logic [CNT_W-1:0]       rd_req_len,
  input  logic                   hdata_valid,
  output logic                   hdata_ready,
  input  logic [7:0]             hdata,
  output logic [8*BUF_BYTES-1:0] buf_flat,
  output logic                   xfer_done
);
  localparam int IDX_W = $clog2(BUF_BYTES + 1);

  logic [CNT_W-1:0] rem;
  logic [IDX_W-1:0] idx;
  logic             take;

  assign rd_req_valid = req_on;
  assign rd_req_addr  = haddr;
  assign rd_req_len   = hcnt;
  assign hdata_ready  = xfer_on && (rem != '0);
  assign take         = hdata_ready && hdata_valid;
  assign xfer_done    = xfer_on && (rem == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem <= '0;
      idx <= '0;
    end else if (req_on) begin
      rem <= hcnt;
      idx <= '0;
    end else if (take) begin
      rem <= rem - 1'b1;
      idx <= idx + 1'b1;
    end
  end

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n) buf_flat[8*g +: 8] <= '0;
      else if (take && idx == IDX_W'(g)) buf_flat[8*g +: 8] <= hdata;
    end
  end
endmodule

// File: rtl/sg_fetch_fsm.sv
module sg_fetch_fsm
  import sg_fetch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] next_ptr,
  input  logic              rd_req_ready,
  input  logic              xfer_done,
  output fetch_state_t      state,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              cnt_wr_en,
  output logic [1:0]        cnt_wr_sel,
  output logic [7:0]        cnt_wr_byte,
  output logic [7:0]        ctrl_word
);
  localparam logic [CNT_W-1:0] SIZE_CNT = CNT_W'(DESC_BYTES);

  fetch_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = ST_LDPTR;
      ST_LDPTR:  nxt = ST_CNT0;
      ST_CNT0:   nxt = ST_CNT1;
      ST_CNT1:   nxt = ST_CNT2;
      ST_CNT2:   nxt = ST_GO;
      ST_GO:     if (rd_req_ready) nxt = ST_XFER;
      ST_XFER:   if (xfer_done) nxt = ST_MIRROR;
      ST_MIRROR: nxt = ST_DONE;
      ST_DONE:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ptr_q <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start) ptr_q <= next_ptr;
    end
  end

  // count bytes go out lowest first, one per cycle
  always_comb begin
    cnt_wr_en   = 1'b0;
    cnt_wr_sel  = 2'd0;
    unique case (state)
      ST_CNT0: begin cnt_wr_en = 1'b1; cnt_wr_sel = 2'd0; end
      ST_CNT1: begin cnt_wr_en = 1'b1; cnt_wr_sel = 2'd1; end
      ST_CNT2: begin cnt_wr_en = 1'b1; cnt_wr_sel = 2'd2; end
      default: ;
    endcase
    cnt_wr_byte = cnt_wr_en ? SIZE_CNT[8*cnt_wr_sel +: 8] : 8'h00;
  end

  always_comb begin
    unique case (state)
      ST_GO:   ctrl_word = CTRL_HOST_EN | CTRL_TO_LOCAL | CTRL_FLUSH;
      ST_XFER: ctrl_word = CTRL_HOST_EN | CTRL_TO_LOCAL;
      default: ctrl_word = 8'h00;
    endcase
  end
endmodule

// File: rtl/sg_fetch_seq.sv
module sg_fetch_seq
  import sg_fetch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] next_ptr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sg_ptr,
  output logic [7:0]        ctrl_word,
  output logic              cnt_wr_en,
  output logic [1:0]        cnt_wr_sel,
  output logic [7:0]        cnt_wr_byte,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic [CNT_W-1:0]  rd_req_len,
  input  logic              hdata_valid,
  output logic              hdata_ready,
  input  logic [7:0]        hdata,
  output logic [31:0]       desc_addr,
  output logic [31:0]       desc_count,
  output logic [CNT_W-1:0]  stcnt
);
  localparam int CNT_BYTES = CNT_W / 8;

  fetch_state_t              state;
  logic [ADDR_W-1:0]         ptr_q;
  logic [ADDR_W-1:0]         haddr;
  logic [CNT_W-1:0]          hcnt;
  logic [8*DESC_BYTES-1:0]   buf_flat;
  logic                      xfer_done;

  sg_fetch_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DESC_BYTES(DESC_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .next_ptr(next_ptr),
    .rd_req_ready(rd_req_ready), .xfer_done(xfer_done), .state(state),
    .ptr_q(ptr_q), .cnt_wr_en(cnt_wr_en), .cnt_wr_sel(cnt_wr_sel),
    .cnt_wr_byte(cnt_wr_byte), .ctrl_word(ctrl_word)
  );

  sg_cnt_regs #(.ADDR_W(ADDR_W), .CNT_BYTES(CNT_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_ld(state == ST_LDPTR), .addr_in(ptr_q),
    .wr_en(cnt_wr_en), .wr_sel(cnt_wr_sel), .wr_byte(cnt_wr_byte),
    .haddr(haddr), .hcnt(hcnt)
  );

  sg_host_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUF_BYTES(DESC_BYTES)) u_dma (
    .clk(clk), .rst_n(rst_n), .req_on(state == ST_GO), .xfer_on(state == ST_XFER),
    .haddr(haddr), .hcnt(hcnt), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
    .hdata_valid(hdata_valid), .hdata_ready(hdata_ready), .hdata(hdata),
    .buf_flat(buf_flat), .xfer_done(xfer_done)
  );

  // bus-side counter mirrors the host count; pointer steps one element
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stcnt  <= '0;
      sg_ptr <= '0;
    end else if (state == ST_MIRROR) begin
      stcnt  <= hcnt;
      sg_ptr <= ptr_q + ADDR_W'(DESC_BYTES);
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign desc_addr  = buf_flat[31:0];
  assign desc_count = buf_flat[63:32];
endmodule

// File: rtl/sg_fetch_chk.sv
module sg_fetch_chk #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int DESC_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              cnt_wr_en,
  input logic [1:0]        cnt_wr_sel,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              hdata_ready,
  input logic [CNT_W-1:0]  stcnt
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  cnt_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_en && cnt_wr_sel == 2'd0) |=> (cnt_wr_en && cnt_wr_sel == 2'd1));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req_valid && !hdata_ready));

  // R6
  mirror_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stcnt == CNT_W'(DESC_BYTES)));
endmodule

bind sg_fetch_seq sg_fetch_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DESC_BYTES(DESC_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cnt_wr_en(cnt_wr_en),
  .cnt_wr_sel(cnt_wr_sel), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .hdata_ready(hdata_ready), .stcnt(stcnt)
);

// File: tb/sg_fetch_seq_bench.sv
module sg_fetch_seq_bench;
  localparam int SZ = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] next_ptr = '0;
  logic        busy, done, cnt_wr_en, rd_req_valid, hdata_ready;
  logic [31:0] sg_ptr, rd_req_addr, desc_addr, desc_count;
  logic [7:0]  ctrl_word, cnt_wr_byte;
  logic [1:0]  cnt_wr_sel;
  logic [23:0] rd_req_len, stcnt;
  logic        rd_req_ready = 1'b0;
  logic        hdata_valid = 1'b0;
  logic [7:0]  hdata = '0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int valid_pct = 100;
  int req_pct = 100;
  bit resp_busy = 1'b0;
  bit acc_q = 1'b0;
  logic [31:0] resp_addr = '0;
  int resp_idx = 0;
  int wr_n = 0;
  int wr_cyc[3];
  logic [1:0] wr_sel_log[3];
  logic [7:0] wr_byte_log[3];

  always #10 clk = ~clk;

  sg_fetch_seq u_sg_fetch_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .next_ptr(next_ptr), .busy(busy),
    .done(done), .sg_ptr(sg_ptr), .ctrl_word(ctrl_word), .cnt_wr_en(cnt_wr_en),
    .cnt_wr_sel(cnt_wr_sel), .cnt_wr_byte(cnt_wr_byte), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
    .hdata_valid(hdata_valid), .hdata_ready(hdata_ready), .hdata(hdata),
    .desc_addr(desc_addr), .desc_count(desc_count), .stcnt(stcnt)
  );

  function automatic logic [7:0] mem(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] le32(input logic [31:0] a);
    return {mem(a + 3), mem(a + 2), mem(a + 1), mem(a)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    acc_q <= hdata_valid && hdata_ready;
  end

  // host responder, driven away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (!resp_busy) begin
        hdata_valid = 1'b0;
        rd_req_ready = rd_req_valid && (($urandom % 100) < req_pct);
        if (rd_req_ready) begin
          // R3
          check("R3 addr", rd_req_addr, next_ptr);
          check("R3 len", {8'h0, rd_req_len}, SZ);
          // R4
          check("R4 ctrl pending", {24'h0, ctrl_word}, 32'h0D);
          resp_addr = rd_req_addr;
          resp_idx = 0;
          resp_busy = 1'b1;
        end
      end else begin
        rd_req_ready = 1'b0;
        if (acc_q) resp_idx++;
        if (resp_idx < SZ) begin
          hdata = mem(resp_addr + resp_idx);
          hdata_valid = (($urandom % 100) < valid_pct);
        end else begin
          hdata_valid = 1'b0;
          resp_busy = 1'b0;
        end
      end
    end
  end

  // monitor: count writes and control word during receive
  initial begin
    forever begin
      @(negedge clk);
      if (cnt_wr_en && wr_n < 3) begin
        wr_sel_log[wr_n] = cnt_wr_sel;
        wr_byte_log[wr_n] = cnt_wr_byte;
        wr_cyc[wr_n] = cyc;
        wr_n++;
      end
      if (hdata_ready && hdata_valid && ctrl_word !== 8'h0C) begin
        // R4
        check("R4 ctrl receive", {24'h0, ctrl_word}, 32'h0C);
      end
    end
  end

  task automatic fetch(input logic [31:0] ptr, input bit poke);
    int t;
    wr_n = 0;
    @(negedge clk);
    start = 1'b1;
    next_ptr = ptr;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 2000) begin
      if (poke && t == 12) begin
        start = 1'b1;
        next_ptr = ~ptr;
      end else begin
        start = 1'b0;
        next_ptr = ptr;
      end
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    next_ptr = ptr;
    if (!done) begin
      check("watchdog done", 0, 1);
      return;
    end
    // R5
    check("R5 desc_addr", desc_addr, le32(ptr));
    check("R5 desc_count", desc_count, le32(ptr + 4));
    // R6
    check("R6 stcnt", {8'h0, stcnt}, SZ);
    // R7
    check("R7 sg_ptr", sg_ptr, ptr + SZ);
    // R4
    check("R4 ctrl done", {24'h0, ctrl_word}, 0);
    // R2
    check("R2 write count", wr_n, 3);
    for (int i = 0; i < 3 && i < wr_n; i++) begin
      check("R2 sel", {30'h0, wr_sel_log[i]}, i);
      check("R2 byte", {24'h0, wr_byte_log[i]}, (SZ >> (8 * i)) & 8'hFF);
      if (i > 0) check("R2 consecutive", wr_cyc[i] - wr_cyc[i-1], 1);
    end
    @(negedge clk);
    // R7
    check("R7 done pulse", {31'h0, done}, 0);
    if (poke) check("R8 idle after ignored start", {31'h0, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1 busy", {31'h0, busy}, 0);
    check("R1 done", {31'h0, done}, 0);
    check("R1 req", {31'h0, rd_req_valid}, 0);
    check("R1 hready", {31'h0, hdata_ready}, 0);
    check("R1 ctrl", {24'h0, ctrl_word}, 0);
    check("R1 stcnt", {8'h0, stcnt}, 0);
    check("R1 sg_ptr", sg_ptr, 0);
    rst_n = 1'b1;
    // directed: no stalls
    valid_pct = 100; req_pct = 100;
    fetch(32'h0000_1000, 1'b0);
    // directed: heavy stalls with a start while busy (R8)
    valid_pct = 20; req_pct = 15;
    fetch(32'h0012_3458, 1'b1);
    // directed: pointer near wrap
    valid_pct = 60; req_pct = 50;
    fetch(32'hFFFF_FFF8, 1'b0);
    for (int n = 0; n < 40; n++) begin
      valid_pct = 10 + ($urandom % 91);
      req_pct = 10 + ($urandom % 91);
      fetch($urandom & 32'hFFFF_FFF8, n[0]);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule